// File: doc/BRIEF.md
# Trace Message Queue with Overflow Reporting

This block collects debug trace messages of several classes and holds them in a small FIFO. Each entry is a message word with a length field, and a downstream serializer drains the FIFO through a valid/ready handshake. Writes to the owner (process identifier) register are turned into fixed-format ownership messages. Branch, data and watchpoint messages arrive already formed, on one shared request port.

When a message arrives and the FIFO is full, the block enters an overflow state. It discards every message offered until the FIFO has drained completely. It then writes one error message, whose code says which classes were lost. After that, normal traffic resumes. An optional stall request tells the CPU to hold off while the FIFO is nearly full. This reduces overruns but cannot prevent them.

Top module: `trace_msg_queue`

## Requirements
- R1: A pulse on `own_wr` latches `own_data` and marks one ownership message pending. A second pulse before the pending message is offered overwrites the latched value, so only one message, carrying the newest value, results.
- R2: An ownership message has length 42. Bits [5:0] are 6'b000010, bits [9:6] are `src_id`, bits [41:10] are the latched process value, and bits [63:42] are zero.
- R3: When `trace_req` is high, the trace message is offered that cycle. Its length is `trace_len`, and its payload is `trace_payload` with bits [9:6] replaced by `src_id`. A pending ownership message is offered only in a cycle with `trace_req` low, starting the cycle after its `own_wr`.
- R4: Entries leave in arrival order. An entry leaves only in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word and length hold.
- R5: A message offered while the FIFO holds DEPTH (8) entries at the start of the cycle is dropped, even if an entry leaves in that cycle. This starts overflow. Every later offer is dropped until the FIFO is empty.
- R6: In the first cycle that overflow holds with an empty FIFO, exactly one error message is written and overflow ends. The error message has length 15, bits [5:0] = 6'b001000, bits [9:6] = `src_id` and bits [14:10] = the error code. Any message offered in that cycle is also dropped and counts toward the code.
- R7: The error code is 5'b01000 if a watchpoint (`trace_class[1]` = 1) was dropped since overflow began. Otherwise it is 5'b00111 if a branch (`trace_class` = 2'b00) or data (2'b01) message was dropped. Otherwise it is 5'b00000.
- R8: `stall_req` is high exactly when `stall_en` is high and the FIFO holds at least 6 entries.
- R9: Reset empties the FIFO, clears the pending ownership message, and clears the overflow state and dropped-class record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_id | input | 4 | Static source identifier placed in every message |
| stall_en | input | 1 | Enables the near-full stall request |
| own_wr | input | 1 | Owner register write strobe |
| own_data | input | 32 | New process identifier value |
| trace_req | input | 1 | Pre-formed trace message offered this cycle |
| trace_class | input | 2 | 00 branch, 01 data, 1x watchpoint |
| trace_payload | input | 64 | Trace message bits, LSB first |
| trace_len | input | 7 | Trace message length in bits |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Consumer takes the head entry |
| out_payload | output | 64 | Head message bits |
| out_len | output | 7 | Head message length |
| stall_req | output | 1 | CPU stall request while near full |

## Verification
The error-format property identifies an error message only by its low six code bits. It therefore assumes that pre-formed trace payloads never carry 6'b001000 or 6'b000010 in bits [5:0]. It also assumes that `src_id` stays constant. The random stimulus forces those low bits to class-specific values. It holds `src_id` fixed, draws `trace_len` from 10 to 64, and throttles `out_ready` so that the FIFO overflows often. Directed cases drive drains that drop only ownership traffic, traffic with branch or data messages, and traffic with a watchpoint. Further directed cases cover a pending ownership overwrite, the stall threshold, and reset in the middle of an overflow.

// File: rtl/trace_msg_queue.sv
module trace_msg_queue #(
  parameter int DEPTH       = 8,
  parameter int PW          = 64,
  parameter int LW          = 7,
  parameter int SRC_W       = 4,
  parameter int PID_W       = 32,
  parameter int STALL_LEVEL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_id,
  input  logic             stall_en,
  input  logic             own_wr,
  input  logic [PID_W-1:0] own_data,
  input  logic             trace_req,
  input  logic [1:0]       trace_class,
  input  logic [PW-1:0]    trace_payload,
  input  logic [LW-1:0]    trace_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PW-1:0]    out_payload,
  output logic [LW-1:0]    out_len,
  output logic             stall_req
);
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int HDR_W   = 6 + SRC_W;
  localparam int OWN_LEN = HDR_W + PID_W;
  localparam int ERR_LEN = HDR_W + 5;
  localparam logic [5:0] TC_OWN = 6'b000010;
  localparam logic [5:0] TC_ERR = 6'b001000;

  logic [PW-1:0]    mem_pl [DEPTH];
  logic [LW-1:0]    mem_ln [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             own_pend, ovf, seen_wp, seen_bd;
  logic [PID_W-1:0] own_pid;

  wire full     = (count == CW'(DEPTH));
  wire offer    = trace_req | own_pend;
  wire offer_wp = trace_req & trace_class[1];
  wire offer_bd = trace_req & ~trace_class[1];
  wire err_slot = ovf & (count == '0);
  wire drop     = offer & (ovf | full);
  wire push     = err_slot | (offer & ~drop);
  wire deq      = out_valid & out_ready;
  wire seen_wp_n = seen_wp | (drop & offer_wp);
  wire seen_bd_n = seen_bd | (drop & offer_bd);

  logic [4:0]    ecode;
  logic [PW-1:0] in_pl;
  logic [LW-1:0] in_ln;

  always_comb begin
    ecode = seen_wp_n ? 5'b01000 : (seen_bd_n ? 5'b00111 : 5'b00000);
    if (err_slot) begin
      in_pl = {{(PW-ERR_LEN){1'b0}}, ecode, src_id, TC_ERR};
      in_ln = LW'(ERR_LEN);
    end else if (trace_req) begin
      in_pl = {trace_payload[PW-1:HDR_W], src_id, trace_payload[5:0]};
      in_ln = trace_len;
    end else begin
      in_pl = {{(PW-OWN_LEN){1'b0}}, own_pid, src_id, TC_OWN};
      in_ln = LW'(OWN_LEN);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_pl[wr_ptr] <= in_pl;
      mem_ln[wr_ptr] <= in_ln;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      own_pend <= 1'b0;
      own_pid  <= '0;
      ovf      <= 1'b0;
      seen_wp  <= 1'b0;
      seen_bd  <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (deq)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(deq);
      if (own_wr) begin
        own_pend <= 1'b1;
        own_pid  <= own_data;
      end else if (!trace_req) begin
        own_pend <= 1'b0;
      end
      if (err_slot) begin
        ovf     <= 1'b0;
        seen_wp <= 1'b0;
        seen_bd <= 1'b0;
      end else begin
        ovf     <= ovf | drop;
        seen_wp <= seen_wp_n;
        seen_bd <= seen_bd_n;
      end
    end
  end

  assign out_valid   = (count != '0);
  assign out_payload = mem_pl[rd_ptr];
  assign out_len     = mem_ln[rd_ptr];
  assign stall_req   = stall_en & (count >= CW'(STALL_LEVEL));

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_payload) && $stable(out_len)); // R4
  AST_ENTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    offer && full |=> ovf); // R5
  AST_DRAIN_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && (count != '0) |=> count <= $past(count)); // R5
  AST_ONE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_slot |=> !ovf && (count == CW'(1))); // R6
  AST_ERR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_payload[5:0] == TC_ERR) |->
      (out_len == LW'(ERR_LEN)) && (out_payload[PW-1:ERR_LEN] == '0)); // R6
  AST_STALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> stall_en && out_valid); // R8
endmodule

// File: tb/tb_trace_msg_queue.sv
module tb_trace_msg_queue;
  localparam int DEPTH = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_id = 4'hA;
  logic        stall_en = 1'b0;
  logic        own_wr = 1'b0;
  logic [31:0] own_data = '0;
  logic        trace_req = 1'b0;
  logic [1:0]  trace_class = '0;
  logic [63:0] trace_payload = '0;
  logic [6:0]  trace_len = 7'd10;
  logic        out_valid, out_ready, stall_req;
  logic [63:0] out_payload;
  logic [6:0]  out_len;

  int checks = 0, failures = 0;
  int n_own = 0;
  logic [31:0] last_pid = '0;
  logic [4:0]  last_err = 5'h1F;

  trace_msg_queue dut (.clk(clk), .rst_n(rst_n), .src_id(src_id), .stall_en(stall_en),
    .own_wr(own_wr), .own_data(own_data), .trace_req(trace_req), .trace_class(trace_class),
    .trace_payload(trace_payload), .trace_len(trace_len), .out_valid(out_valid),
    .out_ready(out_ready), .out_payload(out_payload), .out_len(out_len), .stall_req(stall_req));

  always #2.5 clk = ~clk;

  function automatic logic [70:0] own_word(input logic [31:0] pid, input logic [3:0] s);
    return {7'd42, 22'd0, pid, s, 6'b000010};
  endfunction
  function automatic logic [70:0] err_word(input logic wp, input logic bd, input logic [3:0] s);
    logic [4:0] c;
    c = wp ? 5'b01000 : (bd ? 5'b00111 : 5'b00000);
    return {7'd15, 49'd0, c, s, 6'b001000};
  endfunction
  function automatic logic [70:0] trace_word(input logic [63:0] p, input logic [6:0] l,
                                             input logic [3:0] s);
    return {l, p[63:10], s, p[5:0]};
  endfunction

  logic [70:0] mq[$];
  logic        m_pend = 1'b0, m_ovf = 1'b0, m_wp = 1'b0, m_bd = 1'b0;
  logic [31:0] m_pid = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_pend = 1'b0; m_ovf = 1'b0; m_wp = 1'b0; m_bd = 1'b0;
    end else begin
      int cnt;
      logic owp, obd, offer;
      cnt   = mq.size();
      offer = trace_req || m_pend;
      owp   = trace_req && trace_class[1];
      obd   = trace_req && !trace_class[1];
      if (cnt != 0 && out_ready) void'(mq.pop_front());
      if (m_ovf && cnt == 0) begin
        if (owp) m_wp = 1'b1;
        if (obd) m_bd = 1'b1;
        mq.push_back(err_word(m_wp, m_bd, src_id));
        m_ovf = 1'b0; m_wp = 1'b0; m_bd = 1'b0;
      end else if (offer) begin
        if (m_ovf || cnt == DEPTH) begin
          m_ovf = 1'b1;
          if (owp) m_wp = 1'b1;
          if (obd) m_bd = 1'b1;
        end else begin
          mq.push_back(trace_req ? trace_word(trace_payload, trace_len, src_id)
                                 : own_word(m_pid, src_id));
        end
      end
      if (own_wr) begin m_pend = 1'b1; m_pid = own_data; end
      else if (!trace_req) m_pend = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_payload[5:0] == 6'b000010) begin n_own++; last_pid = out_payload[41:10]; end
      if (out_payload[5:0] == 6'b001000) last_err = out_payload[14:10];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [70:0] act, input logic [70:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [70:0] e;
    chk(out_valid == (mq.size() != 0), "R4 valid", 71'(out_valid), 71'(mq.size() != 0));
    chk(stall_req == (stall_en && mq.size() >= 6), "R8 stall", 71'(stall_req),
        71'(stall_en && mq.size() >= 6));
    if (mq.size() != 0) begin
      e = mq[0];
      chk({out_len, out_payload} == e, "R2/R3/R6 head word", {out_len, out_payload}, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    own_wr = 1'b0; trace_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle_inputs(); out_ready = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic set_trace(input logic [1:0] cls);
    trace_req = 1'b1; trace_class = cls;
    trace_payload = {$urandom, $urandom};
    trace_payload[5:0] = 6'd3 + 6'(cls) * 6'd2;
    trace_len = 7'd10 + 7'($urandom_range(0, 54));
  endtask

  task automatic overflow_case(input int extra, input logic [4:0] exp_code, input string req);
    do_reset();
    out_ready = 1'b0;
    for (int i = 0; i < 10; i++) begin
      own_wr = 1'b1; own_data = $urandom; step();
    end
    own_wr = 1'b0;
    if (extra >= 0) begin set_trace(2'(extra)); step(); trace_req = 1'b0; end
    step();
    last_err = 5'h1F; n_own = 0;
    out_ready = 1'b1;
    repeat (14) step();
    chk(last_err == exp_code, req, 71'(last_err), 71'(exp_code));
    chk(n_own == DEPTH, "R5 only first DEPTH ownership kept", 71'(n_own), 71'(DEPTH));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    out_ready = 1'b0;
    do_reset();
    chk(out_valid == 1'b0 && stall_req == 1'b0, "R9 reset empty", 71'(out_valid), 71'(0));

    // R7 / R6 error codes
    overflow_case(-1, 5'b00000, "R7 code own only");
    overflow_case(0,  5'b00111, "R7 code with branch");
    overflow_case(1,  5'b00111, "R7 code with data");
    overflow_case(2,  5'b01000, "R7 code with watchpoint");

    // R1 overwrite while pending
    do_reset();
    n_own = 0; out_ready = 1'b1;
    set_trace(2'd0); own_wr = 1'b1; own_data = 32'h1111_1111; step();
    own_data = 32'h2222_2222; step();
    own_wr = 1'b0; trace_req = 1'b0;
    repeat (6) step();
    chk(n_own == 1, "R1 one message after overwrite", 71'(n_own), 71'(1));
    chk(last_pid == 32'h2222_2222, "R1 newest value kept", 71'(last_pid), 71'(32'h2222_2222));

    // R8 stall threshold
    do_reset();
    stall_en = 1'b1; out_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin set_trace(2'd1); step(); end
    trace_req = 1'b0; step();
    chk(stall_req == 1'b0, "R8 five entries no stall", 71'(stall_req), 71'(0));
    set_trace(2'd1); step(); trace_req = 1'b0; step();
    chk(stall_req == 1'b1, "R8 six entries stall", 71'(stall_req), 71'(1));
    stall_en = 1'b0; step();
    chk(stall_req == 1'b0, "R8 disabled", 71'(stall_req), 71'(0));

    // R9 reset during overflow
    for (int i = 0; i < 6; i++) begin set_trace(2'd2); step(); end
    trace_req = 1'b0;
    do_reset();
    out_ready = 1'b1; set_trace(2'd0); step(); trace_req = 1'b0; step();
    chk(out_valid == 1'b0, "R9 accepts after reset then drains", 71'(out_valid), 71'(0));

    // random mix
    for (int i = 0; i < 6000; i++) begin
      own_wr = ($urandom_range(0, 3) == 0);
      own_data = $urandom;
      if ($urandom_range(0, 2) == 0) set_trace(2'($urandom_range(0, 3)));
      else trace_req = 1'b0;
      out_ready = ((i / 64) % 2 == 0) ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 1) == 1);
      stall_en = $urandom_range(0, 1);
      step();
    end
    idle_inputs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule